// File: doc/BRIEF.md
# Per-Processor Interval Tick Counters

This block keeps one down-counter for each of up to four processors. All of them share a single periodic tick input. That input is brought into the clock domain and reduced to a single-cycle pulse for each low-to-high transition. On each pulse, every counter whose processor is marked present steps down by one. Each counter is 24 bits wide and has a 25th bit that acts as a sticky overflow flag. The first time the count wraps below zero, this flag sets. It then stays set through later ticks until software reloads the counter. While the flag is set, every tick marks that processor's timer-pending flag and raises its timer interrupt. The flag and the interrupt stay up until an external clear strobe for that processor arrives.

The tick front end is a two-state machine. In TK_LOW it waits for the synchronised tick to read high. When it does, it emits the decrement pulse on the TK_LOW to TK_HIGH transition. In TK_HIGH it stays put until the synchronised tick returns low, which gives the TK_HIGH to TK_LOW transition; this transition produces no pulse. Software reads and reloads the counters through a simple 64-bit register port. Reads are combinational on the address. Writes take effect at the clock edge on which the write enable is sampled.

Top module: `interval_tick_timers`

## Requirements
- R1: After reset, every counter reads 0, and every timer-pending flag and timer interrupt is low.
- R2: Counter i lives at register address 0x380 (i=0), 0x3C0 (i=1), 0x700 (i=2) or 0x740 (i=3). A read returns the 25-bit state in bits 24:0 with zeros above it, and any other address reads 0.
- R3: A write to a counter address loads bits 23:0 of the write data and clears overflow bit 24, whatever the upper data bits are.
- R4: On each tick event, a present counter with value v becomes ((v - 1) mod 2^25) OR (v AND 2^24).
- R5: Once bit 24 is set, it stays set through any number of further ticks until the next write to that counter.
- R6: Each low-to-high transition of the tick input gives exactly one tick event, however long the input stays high. A high-to-low transition gives none. The counter shows the new value after the third rising clock edge that follows the tick's rise.
- R7: When a tick leaves bit 24 of a present counter set, that processor's pending flag and timer interrupt go high.
- R8: A pending flag and its interrupt stay high until the clear strobe bit for that processor is sampled high. The clear then drops them on that edge, unless a new overflow tick sets them in the same cycle.
- R9: A counter whose present input is low keeps its value on tick events and never raises its pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Shared periodic tick, asynchronous |
| cpu_present | input | N_CPU | Per-processor present flags |
| reg_addr | input | 12 | Register byte address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| pend_clr | input | N_CPU | Per-processor pending clear strobes |
| timer_pend | output | N_CPU | Timer-pending flags |
| timer_irq | output | N_CPU | Per-processor timer interrupts |

## Verification
The assertions assume the following about the inputs. The tick input stays in each level for more than one clock, so every transition passes through the synchroniser. The present flags and the register address are driven synchronously, and writes and clears are single-cycle strobes. The stimulus respects this. Each tick is held high for four clocks and then low for four clocks. Present flags change only while no tick is in flight. Writes and clears are driven as one-cycle pulses away from the clock edge. Random reload values are biased toward small counts, so the wrap and sticky-overflow paths are reached often.

// File: rtl/itt_pkg.sv
package itt_pkg;

    localparam int REG_ADDR_W = 12;

    typedef enum logic [0:0] {
        TK_LOW  = 1'b0,
        TK_HIGH = 1'b1
    } tick_state_e;

    // Register address of each counter slot; the order is the processor order.
    function automatic logic [REG_ADDR_W-1:0] slot_addr(input int idx);
        logic [REG_ADDR_W-1:0] a;
        case (idx)
            0:       a = 12'h380;
            1:       a = 12'h3C0;
            2:       a = 12'h700;
            3:       a = 12'h740;
            default: a = 12'hFFF;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/itt_tick_fsm.sv
module itt_tick_fsm
    import itt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async,
    output logic tick_evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    tick_state_e            state_q, state_d;
    logic                   tick_s;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= tick_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], tick_async};
            end
        end
    endgenerate

    assign tick_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TK_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TK_LOW:  if (tick_s)  state_d = TK_HIGH;
            TK_HIGH: if (!tick_s) state_d = TK_LOW;
            default: state_d = TK_LOW;
        endcase
    end

    always_comb begin
        tick_evt = 1'b0;
        unique case (state_q)
            TK_LOW:  tick_evt = tick_s;
            TK_HIGH: tick_evt = 1'b0;
            default: tick_evt = 1'b0;
        endcase
    end

    AST_ONE_EVT_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_evt |=> !tick_evt); // R6
    AST_EVT_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tick_evt |=> state_q == TK_HIGH); // R6

endmodule

// File: rtl/itt_slot.sv
module itt_slot #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             present,
    input  logic             tick_evt,
    input  logic             wr_hit,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             pend_clr,
    output logic [CNT_W:0]   cnt_o,
    output logic             pend_o
);

    logic [CNT_W:0] cnt_q, dec, stepped;
    logic           pend_q, step, pend_set;

    assign dec      = cnt_q - 1'b1;
    assign stepped  = {dec[CNT_W] | cnt_q[CNT_W], dec[CNT_W-1:0]};
    assign step     = tick_evt && present && !wr_hit;
    assign pend_set = step && stepped[CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_hit) begin
            cnt_q <= {1'b0, wr_val};
        end else if (step) begin
            cnt_q <= stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (pend_set)  pend_q <= 1'b1;
        else if (pend_clr)  pend_q <= 1'b0;
    end

    assign cnt_o  = cnt_q;
    assign pend_o = pend_q;

    AST_WRITE_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> !cnt_q[CNT_W]); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q[CNT_W] && !wr_hit |=> cnt_q[CNT_W]); // R5
    AST_ABSENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !present && !wr_hit |=> $stable(cnt_q)); // R9
    AST_ABSENT_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !present && !pend_q |=> !pend_q); // R9
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && !pend_clr |=> pend_q); // R8
    AST_OVF_TICK_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        tick_evt && present && !wr_hit && cnt_q[CNT_W] |=> pend_q); // R7

endmodule

// File: rtl/interval_tick_timers.sv
module interval_tick_timers
    import itt_pkg::*;
#(
    parameter int N_CPU       = 4,
    parameter int CNT_W       = 24,
    parameter int DATA_W      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_in,
    input  logic [N_CPU-1:0]      cpu_present,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr_en,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [N_CPU-1:0]      pend_clr,
    output logic [N_CPU-1:0]      timer_pend,
    output logic [N_CPU-1:0]      timer_irq
);

    localparam int STATE_W = CNT_W + 1;

    logic                              tick_evt;
    logic [N_CPU-1:0]                  wr_hit;
    logic [N_CPU-1:0][STATE_W-1:0]     cnt;

    itt_tick_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_async (tick_in),
        .tick_evt   (tick_evt)
    );

    for (genvar i = 0; i < N_CPU; i++) begin : g_slot
        assign wr_hit[i] = reg_wr_en && (reg_addr == slot_addr(i));

        itt_slot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .present  (cpu_present[i]),
            .tick_evt (tick_evt),
            .wr_hit   (wr_hit[i]),
            .wr_val   (reg_wdata[CNT_W-1:0]),
            .pend_clr (pend_clr[i]),
            .cnt_o    (cnt[i]),
            .pend_o   (timer_pend[i])
        );
    end

    assign timer_irq = timer_pend;

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < N_CPU; i++) begin
            if (reg_addr == slot_addr(i)) reg_rdata = DATA_W'(cnt[i]);
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> timer_pend == '0); // R1
    AST_ONEHOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit)); // R2

endmodule

// File: tb/test_interval_tick_timers.sv
module test_interval_tick_timers;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic [3:0]  cpu_present = 4'hF;
    logic [11:0] reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [3:0]  pend_clr = '0;
    logic [3:0]  timer_pend, timer_irq;

    int n_checks = 0;
    int n_fail = 0;

    logic [24:0] m_cnt [N];
    logic [3:0]  m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_tick_timers i_interval_tick_timers (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .cpu_present(cpu_present),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pend_clr(pend_clr),
        .timer_pend(timer_pend), .timer_irq(timer_irq)
    );

    function automatic logic [11:0] f_addr(input int i);
        case (i)
            0: return 12'h380;
            1: return 12'h3C0;
            2: return 12'h700;
            default: return 12'h740;
        endcase
    endfunction

    function automatic logic [24:0] f_step(input logic [24:0] v);
        logic [24:0] d;
        d = v - 25'd1;
        return {d[24] | v[24], d[23:0]};
    endfunction

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            reg_addr = f_addr(i);
            #1;
            chk(req, reg_rdata, {39'b0, m_cnt[i]});
        end
        chk({req, " pend"}, {60'b0, timer_pend}, {60'b0, m_pend});
        chk({req, " irq"},  {60'b0, timer_irq},  {60'b0, m_pend});
    endtask

    task automatic do_write(input int i, input logic [63:0] v);
        @(negedge clk);
        reg_addr = f_addr(i); reg_wdata = v; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        m_cnt[i] = {1'b0, v[23:0]};
    endtask

    task automatic do_tick;
        @(negedge clk);
        tick_in = 1'b1;
        repeat (4) @(negedge clk);
        tick_in = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < N; i++) begin
            if (cpu_present[i]) begin
                m_cnt[i] = f_step(m_cnt[i]);
                if (m_cnt[i][24]) m_pend[i] = 1'b1;
            end
        end
    endtask

    task automatic do_clear(input logic [3:0] m);
        @(negedge clk);
        pend_clr = m;
        @(negedge clk);
        pend_clr = '0;
        m_pend = m_pend & ~m;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < N; i++) m_cnt[i] = '0;
        m_pend = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R2: unmapped addresses read 0
        @(negedge clk); reg_addr = 12'h400; #1; chk("R2 unmapped", reg_rdata, 64'd0);
        @(negedge clk); reg_addr = 12'h381; #1; chk("R2 unmapped", reg_rdata, 64'd0);

        // R3: upper data bits dropped
        do_write(1, 64'hFFFF_FFFF_FFFF_FFFF);
        do_write(2, 64'h0000_0001_0012_3456);
        check_all("R3 write");

        // R4/R6/R7: count down through wrap
        do_write(0, 64'd2);
        do_tick(); check_all("R4 step");
        do_tick(); check_all("R4 to zero");
        do_tick(); check_all("R7 wrap pends");

        // R6: exact timing, and a long-held tick steps once
        do_write(3, 64'd10);
        @(negedge clk); tick_in = 1'b1;
        @(negedge clk); @(negedge clk); reg_addr = f_addr(3); #1;
        chk("R6 not yet", reg_rdata, 64'd10);
        @(negedge clk); #1;
        chk("R6 third edge", reg_rdata, 64'd9);
        repeat (20) @(negedge clk);
        #1; chk("R6 held high once", reg_rdata, 64'd9);
        tick_in = 1'b0;
        repeat (6) @(negedge clk);
        #1; chk("R6 falling no step", reg_rdata, 64'd9);
        for (int i = 0; i < N; i++) if (cpu_present[i]) begin
            m_cnt[i] = f_step(m_cnt[i]);
            if (m_cnt[i][24]) m_pend[i] = 1'b1;
        end
        check_all("R6 model sync");

        // R8: clear drops pending; R5 sticky re-pends
        do_clear(4'b0001); check_all("R8 clear");
        do_tick(); check_all("R5 sticky");
        do_clear(4'b1110); check_all("R8 clear others");
        do_write(0, 64'd7); check_all("R3 reload clears ovf");

        // R9: absent processor holds
        cpu_present = 4'b1011;
        do_write(2, 64'd0);
        do_tick(); do_tick(); check_all("R9 absent");
        cpu_present = 4'hF;

        // random mix
        for (int k = 0; k < 60; k++) begin
            int op;
            int ci;
            logic [63:0] v;
            op = $urandom_range(0, 3);
            ci = $urandom_range(0, 3);
            case (op)
                0: begin
                    v = {$urandom, $urandom};
                    if ($urandom_range(0, 2) != 0) v = 64'($urandom_range(0, 3));
                    do_write(ci, v);
                    check_all("R3 rand");
                end
                1: begin do_tick(); check_all("R4 rand"); end
                2: begin do_clear(4'($urandom_range(0, 15))); check_all("R8 rand"); end
                default: begin
                    cpu_present = 4'($urandom_range(0, 15));
                    do_tick(); check_all("R9 rand");
                end
            endcase
        end

        report();
    end

endmodule